// File: doc/BRIEF.md
# Binary-Tree State Router Node

This block is one internal node of a binary routing tree whose leaves are processing elements. Interior nodes do no computation: they only move a complete state word, with its routing fields, between the two children below the node and the parent above it. Every link carries a valid bit, a climb count, a destination element index and the state word. The node has one output register on each of its three outgoing links, and it takes a state in only when the target register is empty.

A state that comes up from a child still has a climb count. If the count is above one, the state goes on to the parent with the count reduced by one. If the count is one or less, this node is the common ancestor of the source and the destination, and the state turns down into the other child's subtree. A state that comes down from the parent is steered by one bit of its destination index. The node's level parameter chooses which bit.

Upstream logic holds a state until the node asserts the take strobe for that input. Downstream logic empties an output register by asserting that output's take strobe while the register is valid.

Top module: `tree_route_node`

## Requirements
- R1: After reset, all three output valid bits are 0.
- R2: A valid state from a child with climb count greater than 1 is loaded into the parent output register when that register is empty. It arrives with the climb count reduced by 1, and its destination index and state word are unchanged. It is visible one clock edge after the transfer.
- R3: A valid state from a child with climb count 0 or 1 is loaded into the opposite child's output register (left input to right output, right input to left output), with all fields unchanged.
- R4: A valid state from the parent goes to the left output when destination index bit LEVEL-1 is 0, and to the right output when that bit is 1. All fields are unchanged.
- R5: An output register that holds a valid state is never loaded. The input aimed at it sees its take strobe low, and the register contents stay stable until the register is emptied.
- R6: A valid output register becomes empty one edge after its take input is high, and it cannot be reloaded in that same cycle.
- R7: When both children send a state toward the parent in the same cycle, the left child is granted and the right child is held.
- R8: When the parent and a turning child state both target the same child output, the parent's state is granted and the child's state is held.
- R9: An input's take strobe is high only when that input is valid, the input is being transferred in that cycle, and its target register is empty.
- R10: Inputs aimed at different outputs are all transferred in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lftInVld | input | 1 | Left child upward state valid |
| lftInClimb | input | CLIMB_W | Left child upward climb count |
| lftInDest | input | IDX_W | Left child upward destination index |
| lftInState | input | STATE_W | Left child upward state word |
| lftInTake | output | 1 | Left child upward state accepted this cycle |
| rgtInVld | input | 1 | Right child upward state valid |
| rgtInClimb | input | CLIMB_W | Right child upward climb count |
| rgtInDest | input | IDX_W | Right child upward destination index |
| rgtInState | input | STATE_W | Right child upward state word |
| rgtInTake | output | 1 | Right child upward state accepted this cycle |
| parInVld | input | 1 | Parent downward state valid |
| parInClimb | input | CLIMB_W | Parent downward climb count |
| parInDest | input | IDX_W | Parent downward destination index |
| parInState | input | STATE_W | Parent downward state word |
| parInTake | output | 1 | Parent downward state accepted this cycle |
| parOutVld | output | 1 | Upward output register valid |
| parOutClimb | output | CLIMB_W | Upward output climb count |
| parOutDest | output | IDX_W | Upward output destination index |
| parOutState | output | STATE_W | Upward output state word |
| parOutTake | input | 1 | Parent consumes the upward output |
| lftOutVld | output | 1 | Left downward output valid |
| lftOutClimb | output | CLIMB_W | Left downward output climb count |
| lftOutDest | output | IDX_W | Left downward output destination index |
| lftOutState | output | STATE_W | Left downward output state word |
| lftOutTake | input | 1 | Left child consumes the downward output |
| rgtOutVld | output | 1 | Right downward output valid |
| rgtOutClimb | output | CLIMB_W | Right downward output climb count |
| rgtOutDest | output | IDX_W | Right downward output destination index |
| rgtOutState | output | STATE_W | Right downward output state word |
| rgtOutTake | input | 1 | Right child consumes the downward output |

## Verification
The bench builds the node with a 4-bit destination index, LEVEL of 2 and a 32-bit state word. With these values bit 1 of the index does the steering, so destinations that differ only in bits 0, 2 or 3 show whether the wrong bit is being examined. Climb counts from 0 to 4 cover both the turn-down path and the decrement path.

Occupied registers are built up on purpose. This lets the bench observe holding, reload after the take cycle, and each arbitration order on the output ports.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;

  // Strobes passed from the routing control to the datapath registers.
  typedef struct packed {
    logic loadPar;    // load the upward output register
    logic parFromRgt; // upward source: 0 = left child, 1 = right child
    logic loadLft;    // load the left downward register
    logic lftFromSib; // left source: 0 = parent, 1 = right child turning
    logic loadRgt;    // load the right downward register
    logic rgtFromSib; // right source: 0 = parent, 1 = left child turning
  } route_strobe_t;

endpackage

// File: rtl/tree_route_ctrl.sv
module tree_route_ctrl
  import tree_route_pkg::*;
#(
  parameter int CLIMB_W = 5,
  parameter int IDX_W   = 8,
  parameter int LEVEL   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lftInVld,
  input  logic [CLIMB_W-1:0] lftInClimb,
  input  logic               rgtInVld,
  input  logic [CLIMB_W-1:0] rgtInClimb,
  input  logic               parInVld,
  input  logic [IDX_W-1:0]   parInDest,
  input  logic               parOutVld,
  input  logic               lftOutVld,
  input  logic               rgtOutVld,
  output route_strobe_t      strobe,
  output logic               lftInTake,
  output logic               rgtInTake,
  output logic               parInTake
);

  localparam int SEL_BIT = LEVEL - 1;
  localparam logic [CLIMB_W-1:0] TURN_AT = CLIMB_W'(1);

  logic lftUp, lftTurn, rgtUp, rgtTurn, parGoLft, parGoRgt;
  logic parFree, lftFree, rgtFree;

  always_comb begin
    lftUp    = lftInVld && (lftInClimb > TURN_AT);
    lftTurn  = lftInVld && !(lftInClimb > TURN_AT);
    rgtUp    = rgtInVld && (rgtInClimb > TURN_AT);
    rgtTurn  = rgtInVld && !(rgtInClimb > TURN_AT);
    parGoRgt = parInVld && parInDest[SEL_BIT];
    parGoLft = parInVld && !parInDest[SEL_BIT];
    parFree  = !parOutVld;
    lftFree  = !lftOutVld;
    rgtFree  = !rgtOutVld;
  end

  // Upward register: left child first. Child registers: parent first.
  always_comb begin
    strobe            = '0;
    strobe.loadPar    = parFree && (lftUp || rgtUp);
    strobe.parFromRgt = !lftUp;
    strobe.loadLft    = lftFree && (parGoLft || rgtTurn);
    strobe.lftFromSib = !parGoLft;
    strobe.loadRgt    = rgtFree && (parGoRgt || lftTurn);
    strobe.rgtFromSib = !parGoRgt;
  end

  always_comb begin
    lftInTake = (lftUp && parFree) || (lftTurn && rgtFree && !parGoRgt);
    rgtInTake = (rgtUp && parFree && !lftUp) || (rgtTurn && lftFree && !parGoLft);
    parInTake = (parGoLft && lftFree) || (parGoRgt && rgtFree);
  end

  // R9: a take strobe never fires without a valid input
  a_r9_take_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (lftInTake |-> lftInVld) and (rgtInTake |-> rgtInVld) and (parInTake |-> parInVld));

  // R5: nothing is accepted toward an occupied upward register
  a_r5_no_take_when_full: assert property (@(posedge clk) disable iff (!rstN)
    ((lftInTake && lftInClimb > TURN_AT) || (rgtInTake && rgtInClimb > TURN_AT)) |-> !parOutVld);

  // R7: left child wins the parent link
  a_r7_left_first: assert property (@(posedge clk) disable iff (!rstN)
    (lftInVld && lftInClimb > TURN_AT && rgtInVld && rgtInClimb > TURN_AT) |-> !rgtInTake);

  // R8: parent wins a child link over a turning sibling
  a_r8_parent_first: assert property (@(posedge clk) disable iff (!rstN)
    (parInVld && !parInDest[SEL_BIT] && rgtInVld && !(rgtInClimb > TURN_AT)) |-> !rgtInTake);

endmodule

// File: rtl/tree_route_dpath.sv
module tree_route_dpath
  import tree_route_pkg::*;
#(
  parameter int CLIMB_W = 5,
  parameter int IDX_W   = 8,
  parameter int STATE_W = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  route_strobe_t      strobe,
  input  logic [CLIMB_W-1:0] lftInClimb,
  input  logic [IDX_W-1:0]   lftInDest,
  input  logic [STATE_W-1:0] lftInState,
  input  logic [CLIMB_W-1:0] rgtInClimb,
  input  logic [IDX_W-1:0]   rgtInDest,
  input  logic [STATE_W-1:0] rgtInState,
  input  logic [CLIMB_W-1:0] parInClimb,
  input  logic [IDX_W-1:0]   parInDest,
  input  logic [STATE_W-1:0] parInState,
  input  logic               parOutTake,
  input  logic               lftOutTake,
  input  logic               rgtOutTake,
  output logic               parOutVld,
  output logic [CLIMB_W-1:0] parOutClimb,
  output logic [IDX_W-1:0]   parOutDest,
  output logic [STATE_W-1:0] parOutState,
  output logic               lftOutVld,
  output logic [CLIMB_W-1:0] lftOutClimb,
  output logic [IDX_W-1:0]   lftOutDest,
  output logic [STATE_W-1:0] lftOutState,
  output logic               rgtOutVld,
  output logic [CLIMB_W-1:0] rgtOutClimb,
  output logic [IDX_W-1:0]   rgtOutDest,
  output logic [STATE_W-1:0] rgtOutState
);

  localparam int NUM_CHILD = 2; // index 0 = left, 1 = right
  localparam logic [CLIMB_W-1:0] STEP = CLIMB_W'(1);

  // Upward register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      parOutVld   <= 1'b0;
      parOutClimb <= '0;
      parOutDest  <= '0;
      parOutState <= '0;
    end else if (strobe.loadPar) begin
      parOutVld   <= 1'b1;
      parOutClimb <= (strobe.parFromRgt ? rgtInClimb : lftInClimb) - STEP;
      parOutDest  <= strobe.parFromRgt ? rgtInDest : lftInDest;
      parOutState <= strobe.parFromRgt ? rgtInState : lftInState;
    end else if (parOutTake) begin
      parOutVld   <= 1'b0;
    end
  end

  // Child-side views as arrays so both downward registers share one body
  logic [CLIMB_W-1:0] chInClimb [NUM_CHILD];
  logic [IDX_W-1:0]   chInDest  [NUM_CHILD];
  logic [STATE_W-1:0] chInState [NUM_CHILD];
  logic               chLoad    [NUM_CHILD];
  logic               chFromSib [NUM_CHILD];
  logic               chTake    [NUM_CHILD];
  logic               chVld     [NUM_CHILD];
  logic [CLIMB_W-1:0] chClimb   [NUM_CHILD];
  logic [IDX_W-1:0]   chDest    [NUM_CHILD];
  logic [STATE_W-1:0] chState   [NUM_CHILD];

  always_comb begin
    chInClimb[0] = lftInClimb;  chInClimb[1] = rgtInClimb;
    chInDest[0]  = lftInDest;   chInDest[1]  = rgtInDest;
    chInState[0] = lftInState;  chInState[1] = rgtInState;
    chLoad[0]    = strobe.loadLft;    chLoad[1]    = strobe.loadRgt;
    chFromSib[0] = strobe.lftFromSib; chFromSib[1] = strobe.rgtFromSib;
    chTake[0]    = lftOutTake;  chTake[1]    = rgtOutTake;
  end

  for (genvar s = 0; s < NUM_CHILD; s++) begin : g_child
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chVld[s]   <= 1'b0;
        chClimb[s] <= '0;
        chDest[s]  <= '0;
        chState[s] <= '0;
      end else if (chLoad[s]) begin
        chVld[s]   <= 1'b1;
        chClimb[s] <= chFromSib[s] ? chInClimb[1-s] : parInClimb;
        chDest[s]  <= chFromSib[s] ? chInDest[1-s]  : parInDest;
        chState[s] <= chFromSib[s] ? chInState[1-s] : parInState;
      end else if (chTake[s]) begin
        chVld[s]   <= 1'b0;
      end
    end

    // R5: an occupied register that is not taken keeps its state
    a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
      (chVld[s] && !chTake[s]) |=> (chVld[s] && $stable(chState[s])));

    // R6: a taken register is empty next cycle
    a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
      (chVld[s] && chTake[s]) |=> !chVld[s]);
  end

  always_comb begin
    lftOutVld = chVld[0];   lftOutClimb = chClimb[0];
    lftOutDest = chDest[0]; lftOutState = chState[0];
    rgtOutVld = chVld[1];   rgtOutClimb = chClimb[1];
    rgtOutDest = chDest[1]; rgtOutState = chState[1];
  end

  // R2: upward forward from left carries the decremented count
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadPar && !strobe.parFromRgt) |=> (parOutClimb == $past(lftInClimb) - STEP));

  // R6: upward register empties after a take
  a_r6_par_clear: assert property (@(posedge clk) disable iff (!rstN)
    (parOutVld && parOutTake) |=> !parOutVld);

  // R5: occupied upward register holds its state
  a_r5_par_hold: assert property (@(posedge clk) disable iff (!rstN)
    (parOutVld && !parOutTake) |=> (parOutVld && $stable(parOutState)));

endmodule

// File: rtl/tree_route_node.sv
module tree_route_node
  import tree_route_pkg::*;
#(
  parameter int CLIMB_W = 5,
  parameter int IDX_W   = 8,
  parameter int LEVEL   = 3,
  parameter int STATE_W = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lftInVld,
  input  logic [CLIMB_W-1:0] lftInClimb,
  input  logic [IDX_W-1:0]   lftInDest,
  input  logic [STATE_W-1:0] lftInState,
  output logic               lftInTake,
  input  logic               rgtInVld,
  input  logic [CLIMB_W-1:0] rgtInClimb,
  input  logic [IDX_W-1:0]   rgtInDest,
  input  logic [STATE_W-1:0] rgtInState,
  output logic               rgtInTake,
  input  logic               parInVld,
  input  logic [CLIMB_W-1:0] parInClimb,
  input  logic [IDX_W-1:0]   parInDest,
  input  logic [STATE_W-1:0] parInState,
  output logic               parInTake,
  output logic               parOutVld,
  output logic [CLIMB_W-1:0] parOutClimb,
  output logic [IDX_W-1:0]   parOutDest,
  output logic [STATE_W-1:0] parOutState,
  input  logic               parOutTake,
  output logic               lftOutVld,
  output logic [CLIMB_W-1:0] lftOutClimb,
  output logic [IDX_W-1:0]   lftOutDest,
  output logic [STATE_W-1:0] lftOutState,
  input  logic               lftOutTake,
  output logic               rgtOutVld,
  output logic [CLIMB_W-1:0] rgtOutClimb,
  output logic [IDX_W-1:0]   rgtOutDest,
  output logic [STATE_W-1:0] rgtOutState,
  input  logic               rgtOutTake
);

  route_strobe_t strobe;

  tree_route_ctrl #(.CLIMB_W(CLIMB_W), .IDX_W(IDX_W), .LEVEL(LEVEL)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lftInVld(lftInVld), .lftInClimb(lftInClimb),
    .rgtInVld(rgtInVld), .rgtInClimb(rgtInClimb),
    .parInVld(parInVld), .parInDest(parInDest),
    .parOutVld(parOutVld), .lftOutVld(lftOutVld), .rgtOutVld(rgtOutVld),
    .strobe(strobe),
    .lftInTake(lftInTake), .rgtInTake(rgtInTake), .parInTake(parInTake)
  );

  tree_route_dpath #(.CLIMB_W(CLIMB_W), .IDX_W(IDX_W), .STATE_W(STATE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lftInClimb(lftInClimb), .lftInDest(lftInDest), .lftInState(lftInState),
    .rgtInClimb(rgtInClimb), .rgtInDest(rgtInDest), .rgtInState(rgtInState),
    .parInClimb(parInClimb), .parInDest(parInDest), .parInState(parInState),
    .parOutTake(parOutTake), .lftOutTake(lftOutTake), .rgtOutTake(rgtOutTake),
    .parOutVld(parOutVld), .parOutClimb(parOutClimb),
    .parOutDest(parOutDest), .parOutState(parOutState),
    .lftOutVld(lftOutVld), .lftOutClimb(lftOutClimb),
    .lftOutDest(lftOutDest), .lftOutState(lftOutState),
    .rgtOutVld(rgtOutVld), .rgtOutClimb(rgtOutClimb),
    .rgtOutDest(rgtOutDest), .rgtOutState(rgtOutState)
  );

endmodule

// File: tb/tb_tree_route_node.sv
module tb_tree_route_node;

  localparam int CLK_PERIOD = 10;
  localparam int CLIMB_W = 5;
  localparam int IDX_W   = 4;
  localparam int LEVEL   = 2;
  localparam int STATE_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lftInVld, rgtInVld, parInVld;
  logic [CLIMB_W-1:0] lftInClimb, rgtInClimb, parInClimb;
  logic [IDX_W-1:0] lftInDest, rgtInDest, parInDest;
  logic [STATE_W-1:0] lftInState, rgtInState, parInState;
  logic lftInTake, rgtInTake, parInTake;
  logic parOutVld, lftOutVld, rgtOutVld;
  logic [CLIMB_W-1:0] parOutClimb, lftOutClimb, rgtOutClimb;
  logic [IDX_W-1:0] parOutDest, lftOutDest, rgtOutDest;
  logic [STATE_W-1:0] parOutState, lftOutState, rgtOutState;
  logic parOutTake, lftOutTake, rgtOutTake;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  tree_route_node #(.CLIMB_W(CLIMB_W), .IDX_W(IDX_W), .LEVEL(LEVEL), .STATE_W(STATE_W)) dut (
    .clk(clk), .rstN(rstN),
    .lftInVld(lftInVld), .lftInClimb(lftInClimb), .lftInDest(lftInDest),
    .lftInState(lftInState), .lftInTake(lftInTake),
    .rgtInVld(rgtInVld), .rgtInClimb(rgtInClimb), .rgtInDest(rgtInDest),
    .rgtInState(rgtInState), .rgtInTake(rgtInTake),
    .parInVld(parInVld), .parInClimb(parInClimb), .parInDest(parInDest),
    .parInState(parInState), .parInTake(parInTake),
    .parOutVld(parOutVld), .parOutClimb(parOutClimb), .parOutDest(parOutDest),
    .parOutState(parOutState), .parOutTake(parOutTake),
    .lftOutVld(lftOutVld), .lftOutClimb(lftOutClimb), .lftOutDest(lftOutDest),
    .lftOutState(lftOutState), .lftOutTake(lftOutTake),
    .rgtOutVld(rgtOutVld), .rgtOutClimb(rgtOutClimb), .rgtOutDest(rgtOutDest),
    .rgtOutState(rgtOutState), .rgtOutTake(rgtOutTake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleIn();
    lftInVld = 0; lftInClimb = '0; lftInDest = '0; lftInState = '0;
    rgtInVld = 0; rgtInClimb = '0; rgtInDest = '0; rgtInState = '0;
    parInVld = 0; parInClimb = '0; parInDest = '0; parInState = '0;
  endtask

  task automatic drain();
    idleIn();
    parOutTake = 1; lftOutTake = 1; rgtOutTake = 1;
    tick();
    parOutTake = 0; lftOutTake = 0; rgtOutTake = 0;
  endtask

  task automatic sendLft(input logic [CLIMB_W-1:0] c, input logic [IDX_W-1:0] d, input logic [STATE_W-1:0] s);
    lftInVld = 1; lftInClimb = c; lftInDest = d; lftInState = s;
  endtask
  task automatic sendRgt(input logic [CLIMB_W-1:0] c, input logic [IDX_W-1:0] d, input logic [STATE_W-1:0] s);
    rgtInVld = 1; rgtInClimb = c; rgtInDest = d; rgtInState = s;
  endtask
  task automatic sendPar(input logic [CLIMB_W-1:0] c, input logic [IDX_W-1:0] d, input logic [STATE_W-1:0] s);
    parInVld = 1; parInClimb = c; parInDest = d; parInState = s;
  endtask

  task automatic testReset();
    chk("R1 parOutVld", parOutVld, 0);
    chk("R1 lftOutVld", lftOutVld, 0);
    chk("R1 rgtOutVld", rgtOutVld, 0);
  endtask

  task automatic testUpward();
    sendLft(5'd3, 4'h9, 32'hA1);
    #1 chk("R9 lftInTake", lftInTake, 1);
    tick();
    idleIn();
    chk("R2 parOutVld", parOutVld, 1);
    chk("R2 climb decremented", parOutClimb, 2);
    chk("R2 dest", parOutDest, 4'h9);
    chk("R2 state", parOutState, 32'hA1);
    chk("R2 no child output", {lftOutVld, rgtOutVld}, 0);
    parOutTake = 1;
    tick();
    parOutTake = 0;
    chk("R6 cleared after take", parOutVld, 0);
  endtask

  task automatic testTurn();
    sendRgt(5'd1, 4'h2, 32'hB1);
    #1 chk("R3 rgtInTake", rgtInTake, 1);
    tick();
    idleIn();
    chk("R3 right turns to left", lftOutVld, 1);
    chk("R3 state", lftOutState, 32'hB1);
    chk("R3 climb kept", lftOutClimb, 1);
    chk("R3 not upward", parOutVld, 0);
    sendLft(5'd0, 4'hC, 32'hB2);
    tick();
    idleIn();
    chk("R3 left count 0 turns right", rgtOutVld, 1);
    chk("R3 state", rgtOutState, 32'hB2);
    drain();
  endtask

  task automatic testDown();
    sendPar(5'd1, 4'b0010, 32'hC1);
    #1 chk("R9 parInTake", parInTake, 1);
    tick();
    idleIn();
    chk("R4 bit1=1 goes right", rgtOutVld, 1);
    chk("R4 left untouched", lftOutVld, 0);
    chk("R4 state", rgtOutState, 32'hC1);
    chk("R4 dest", rgtOutDest, 4'b0010);
    drain();
    sendPar(5'd1, 4'b1101, 32'hC2);
    tick();
    idleIn();
    chk("R4 bit1=0 goes left", lftOutVld, 1);
    chk("R4 right untouched", rgtOutVld, 0);
    chk("R4 state", lftOutState, 32'hC2);
    drain();
  endtask

  task automatic testHold();
    sendLft(5'd2, 4'h1, 32'hD1);
    tick();
    idleIn();
    sendRgt(5'd2, 4'h3, 32'hD2);
    #1 chk("R5 no take while full", rgtInTake, 0);
    tick();
    chk("R5 state held", parOutState, 32'hD1);
    chk("R5 still full", parOutVld, 1);
    parOutTake = 1;
    #1 chk("R6 no reload in take cycle", rgtInTake, 0);
    tick();
    parOutTake = 0;
    #1 chk("R6 empty after take", parOutVld, 0);
    chk("R5 take once empty", rgtInTake, 1);
    tick();
    idleIn();
    chk("R5 held state delivered", parOutState, 32'hD2);
    chk("R2 right climb decremented", parOutClimb, 1);
    drain();
  endtask

  task automatic testArbUp();
    sendLft(5'd4, 4'h5, 32'hE1);
    sendRgt(5'd2, 4'h6, 32'hE2);
    #1 chk("R7 left granted", lftInTake, 1);
    chk("R7 right held", rgtInTake, 0);
    tick();
    lftInVld = 0;
    chk("R7 left state first", parOutState, 32'hE1);
    parOutTake = 1;
    tick();
    parOutTake = 0;
    tick();
    idleIn();
    chk("R7 right state second", parOutState, 32'hE2);
    drain();
  endtask

  task automatic testArbDown();
    sendPar(5'd1, 4'b0000, 32'hF1);
    sendRgt(5'd1, 4'h4, 32'hF2);
    #1 chk("R8 parent granted", parInTake, 1);
    chk("R8 sibling held", rgtInTake, 0);
    tick();
    parInVld = 0;
    chk("R8 parent state first", lftOutState, 32'hF1);
    lftOutTake = 1;
    tick();
    lftOutTake = 0;
    tick();
    idleIn();
    chk("R8 sibling state second", lftOutState, 32'hF2);
    drain();
  endtask

  task automatic testConcurrent();
    sendLft(5'd3, 4'h8, 32'h61);
    sendPar(5'd1, 4'b0010, 32'h62);
    #1 chk("R10 left taken", lftInTake, 1);
    chk("R10 parent taken", parInTake, 1);
    tick();
    idleIn();
    chk("R10 upward loaded", parOutState, 32'h61);
    chk("R10 right loaded", rgtOutState, 32'h62);
    chk("R10 both valid", {parOutVld, rgtOutVld}, 2'b11);
    drain();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idleIn();
    parOutTake = 0; lftOutTake = 0; rgtOutTake = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testUpward();
    testTurn();
    testDown();
    testHold();
    testArbUp();
    testArbDown();
    testConcurrent();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule